// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Sequencer

This block moves a processor core between voltage/frequency operating points on request. An operating point is an 11-bit value: a 5-bit frequency code (larger code means higher clock) in bits [10:6] and a 6-bit voltage code in bits [5:0]. The voltage code maps to supply voltage as 1708 mV minus 16 mV per code step, so code 0 is the highest supply and code 63 the lowest. Software writes a target point through a small write port. The sequencer steps the voltage code one code at a time, with a programmable dwell between steps. It asks the clock generator to relock to the new frequency and waits for a lock acknowledge. Which of these two goes first depends on the direction of the move. While a move runs, the core is flagged unavailable and snoops are held off.

A thermal path watches a die-hot input. When the die gets hot, the sequencer saves the point it is running at and drops to a software-programmed low point. It then waits a fixed hold time and checks the temperature again. If the die has cooled, it climbs back. Otherwise it stays low and starts a new hold. Every thermal move in either direction raises a one-cycle interrupt. A request that arrives while a move is running waits for that move to finish. A request that arrives during throttling waits until the throttle is released.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, vid_out is RST_VID and pll_freq is RST_FREQ. relock_req, core_unavail, snoop_block, thermal_irq and lock_err are all 0.
- R2: The write port decodes wr_addr as follows: 0 writes the target point, 1 writes the thermal low point, and 2 writes the dwell value from wr_data[DWELL_W-1:0]. During a move, vid_out changes by exactly one code at a time. Each intermediate code is held for dwell+1 cycles.
- R3: On a move whose frequency code rises, vid_out reaches its target before relock_req is first raised. On a move whose frequency code falls, vid_out does not change until relock_req has dropped. vid_out is stable while relock_req is high. When the move ends, vid_out and pll_freq equal the target.
- R4: A request for the point already in force completes with no assertion of core_unavail and no change on vid_out or pll_freq.
- R5: core_unavail and snoop_block are high for the whole of a move and low when no move runs. relock_req is high only during a move.
- R6: A target written while a move runs is held and started after the move completes. If several are written, only the last one is carried out.
- R7: When die_hot is high and no throttle is active, the sequencer moves to the thermal low point and pulses thermal_irq for one cycle.
- R8: Once the throttle move ends and HOLD cycles have passed, die_hot is sampled. If it is low, the saved point is restored and thermal_irq pulses. If it is high, the point stays and no interrupt is raised.
- R9: A target written during throttling causes no move. On release, that target is used instead of the saved point.
- R10: If lock_done does not arrive within LOCK_TO cycles of relock_req, lock_err is set and stays set, and the move carries on as if locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 target, 1 thermal low point, 2 dwell |
| wr_data | input | 11 | Write data; a point is {freq[4:0], vid[5:0]} |
| die_hot | input | 1 | Die temperature above limit |
| lock_done | input | 1 | Clock generator lock acknowledge |
| vid_out | output | 6 | Voltage code driven to the regulator |
| pll_freq | output | 5 | Frequency code requested from the clock generator |
| relock_req | output | 1 | Relock request, held until lock or timeout |
| core_unavail | output | 1 | Core unavailable during a move |
| snoop_block | output | 1 | Bus-not-ready style snoop hold-off during a move |
| thermal_irq | output | 1 | One-cycle pulse on each thermal move |
| lock_err | output | 1 | Sticky lock-timeout flag |

## Verification
The hardest case to reach is a software request that lands while a throttle is in force. The throttle must be held through at least one failed cool-down check, and release must then take the recorded request instead of the saved point. The bench writes a target while die_hot is held high for several hold periods. It confirms that no move starts, then drops die_hot and checks where the point settles. A second hard case is a request chain written during a running move. The bench launches a long voltage ramp and issues two more writes while it runs. The completion log must show only the first and last targets.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    localparam int FREQ_W = 5;
    localparam int VID_W  = 6;
    localparam int PT_W   = FREQ_W + VID_W;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [VID_W-1:0]  vid;
    } op_point_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VRAMP  = 2'd1,
        ST_RELOCK = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        RA_TARGET = 2'd0,
        RA_LOWPT  = 2'd1,
        RA_DWELL  = 2'd2
    } reg_addr_t;

    // Millivolts for a voltage code: 16 mV per step below 1708 mV.
    function automatic int vid_to_mv(input logic [VID_W-1:0] code);
        return 1708 - 16 * int'(code);
    endfunction

    // First phase of a move: a falling frequency relocks first,
    // otherwise the voltage is ramped first (if it needs to change).
    function automatic seq_state_t first_phase(input op_point_t cur, input op_point_t tgt);
        if (tgt.freq < cur.freq)
            return ST_RELOCK;
        else if (tgt.vid != cur.vid)
            return ST_VRAMP;
        else
            return ST_RELOCK;
    endfunction

endpackage

// File: rtl/dvfs_vid_ramp.sv
module dvfs_vid_ramp
    import dvfs_pkg::*;
#(
    parameter int DWELL_W = 8,
    parameter int RST_VID = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [VID_W-1:0]   target,
    input  logic [DWELL_W-1:0] dwell,
    output logic [VID_W-1:0]   vid
);

    logic [DWELL_W-1:0] cnt;
    logic               up;

    assign up = target > vid;

    always_ff @(posedge clk) begin
        if (rst) begin
            vid <= VID_W'(RST_VID);
            cnt <= '0;
        end else if (!en || vid == target) begin
            cnt <= '0;
        end else if (cnt == dwell) begin
            cnt <= '0;
            vid <= up ? vid + VID_W'(1) : vid - VID_W'(1);
        end else begin
            cnt <= cnt + DWELL_W'(1);
        end
    end

endmodule

// File: rtl/dvfs_lock_wait.sv
module dvfs_lock_wait #(
    parameter int LOCK_TO = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lock_done,
    output logic finish,
    output logic timed_out
);

    localparam int LK_W = $clog2(LOCK_TO + 1);

    logic [LK_W-1:0] cnt;
    logic            limit;

    assign limit     = cnt == LK_W'(LOCK_TO - 1);
    assign finish    = en && (lock_done || limit);
    assign timed_out = en && !lock_done && limit;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (!limit)
            cnt <= cnt + LK_W'(1);
    end

endmodule

// File: rtl/dvfs_hold_timer.sv
module dvfs_hold_timer #(
    parameter int HOLD = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic expired
);

    localparam int HD_W = $clog2(HOLD + 1);

    logic [HD_W-1:0] cnt;

    assign expired = cnt == HD_W'(HOLD);

    always_ff @(posedge clk) begin
        if (rst || !en || clr)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + HD_W'(1);
    end

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int DWELL_W   = 8,
    parameter int DWELL_RST = 2,
    parameter int LOCK_TO   = 1000,
    parameter int HOLD      = 5000,
    parameter int RST_FREQ  = 8,
    parameter int RST_VID   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [PT_W-1:0]   wr_data,
    input  logic              die_hot,
    input  logic              lock_done,
    output logic [VID_W-1:0]  vid_out,
    output logic [FREQ_W-1:0] pll_freq,
    output logic              relock_req,
    output logic              core_unavail,
    output logic              snoop_block,
    output logic              thermal_irq,
    output logic              lock_err
);

    seq_state_t         state;
    op_point_t          tgt, saved, low_pt, pend, cur_pt, start_pt;
    logic               pend_v, throttled;
    logic [DWELL_W-1:0] dwell;
    logic [FREQ_W-1:0]  freq_q;
    logic [VID_W-1:0]   vid_w;
    logic               lk_finish, lk_timeout, hold_exp;
    logic               idle, therm_down, therm_up, sw_go, launch, hold_restart;
    logic               wr_target;

    assign cur_pt    = '{freq: freq_q, vid: vid_w};
    assign idle      = state == ST_IDLE;
    assign wr_target = wr_en && wr_addr == RA_TARGET;

    // Launch selection: thermal first, then a deferred software target.
    always_comb begin
        therm_down = 1'b0;
        therm_up   = 1'b0;
        sw_go      = 1'b0;
        start_pt   = pend;
        if (throttled) begin
            if (hold_exp && !die_hot) begin
                therm_up = 1'b1;
                start_pt = pend_v ? pend : saved;
            end
        end else if (die_hot) begin
            therm_down = 1'b1;
            start_pt   = low_pt;
        end else if (pend_v) begin
            sw_go = 1'b1;
        end
    end

    assign launch       = idle && (therm_down || therm_up || sw_go);
    assign hold_restart = idle && throttled && hold_exp && die_hot;

    dvfs_vid_ramp #(.DWELL_W(DWELL_W), .RST_VID(RST_VID)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .en     (state == ST_VRAMP),
        .target (tgt.vid),
        .dwell  (dwell),
        .vid    (vid_w)
    );

    dvfs_lock_wait #(.LOCK_TO(LOCK_TO)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .en        (state == ST_RELOCK),
        .lock_done (lock_done),
        .finish    (lk_finish),
        .timed_out (lk_timeout)
    );

    dvfs_hold_timer #(.HOLD(HOLD)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .en      (throttled && idle),
        .clr     (hold_restart),
        .expired (hold_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tgt       <= '{freq: FREQ_W'(RST_FREQ), vid: VID_W'(RST_VID)};
            saved     <= '{freq: FREQ_W'(RST_FREQ), vid: VID_W'(RST_VID)};
            low_pt    <= '{freq: FREQ_W'(RST_FREQ), vid: VID_W'(RST_VID)};
            pend      <= '0;
            pend_v    <= 1'b0;
            throttled <= 1'b0;
            dwell     <= DWELL_W'(DWELL_RST);
            freq_q    <= FREQ_W'(RST_FREQ);
            lock_err  <= 1'b0;
            thermal_irq <= 1'b0;
        end else begin
            thermal_irq <= launch && (therm_down || therm_up);

            if (wr_en && wr_addr == RA_LOWPT)
                low_pt <= op_point_t'(wr_data);
            if (wr_en && wr_addr == RA_DWELL)
                dwell <= wr_data[DWELL_W-1:0];

            if (wr_target) begin
                pend   <= op_point_t'(wr_data);
                pend_v <= 1'b1;
            end else if (launch && (sw_go || therm_up)) begin
                pend_v <= 1'b0;
            end

            if (lk_timeout)
                lock_err <= 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        tgt <= start_pt;
                        if (therm_down) begin
                            saved     <= cur_pt;
                            throttled <= 1'b1;
                        end
                        if (therm_up)
                            throttled <= 1'b0;
                        if (start_pt != cur_pt) begin
                            state <= first_phase(cur_pt, start_pt);
                            if (first_phase(cur_pt, start_pt) == ST_RELOCK)
                                freq_q <= start_pt.freq;
                        end
                    end
                end
                ST_VRAMP: begin
                    if (vid_w == tgt.vid) begin
                        if (freq_q != tgt.freq) begin
                            state  <= ST_RELOCK;
                            freq_q <= tgt.freq;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_RELOCK: begin
                    if (lk_finish)
                        state <= (vid_w != tgt.vid) ? ST_VRAMP : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign vid_out      = vid_w;
    assign pll_freq     = freq_q;
    assign relock_req   = state == ST_RELOCK;
    assign core_unavail = !idle;
    assign snoop_block  = !idle;

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk
    import dvfs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [VID_W-1:0]  vid_out,
    input logic              relock_req,
    input logic              core_unavail,
    input logic              lock_err
);

    // R2: the voltage code moves by one step at a time
    assert_vid_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (vid_out != $past(vid_out)) |->
            (vid_out == $past(vid_out) + 6'd1 || vid_out == $past(vid_out) - 6'd1));

    // R3: voltage code frozen while a relock is pending
    assert_vid_frozen_in_relock_R3: assert property (@(posedge clk) disable iff (rst)
        (relock_req && $past(relock_req)) |-> $stable(vid_out));

    // R5: relock only inside a move
    assert_relock_inside_move_R5: assert property (@(posedge clk) disable iff (rst)
        relock_req |-> core_unavail);

    // R5: no voltage activity outside a move
    assert_idle_vid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !core_unavail |=> $stable(vid_out));

    // R10: lock error is sticky
    assert_lock_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> lock_err);

endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vid_out      (vid_out),
    .relock_req   (relock_req),
    .core_unavail (core_unavail),
    .lock_err     (lock_err)
);

// File: tb/sim_dvfs_seq.sv
`timescale 1ns/1ps
module sim_dvfs_seq;
    import dvfs_pkg::*;

    localparam int LOCK_TO = 20;
    localparam int HOLD    = 40;
    localparam int RFREQ   = 8;
    localparam int RVID    = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [PT_W-1:0]   wr_data = '0;
    logic              die_hot = 1'b0;
    logic              lock_done = 1'b0;
    logic [VID_W-1:0]  vid_out;
    logic [FREQ_W-1:0] pll_freq;
    logic              relock_req, core_unavail, snoop_block, thermal_irq, lock_err;

    dvfs_seq #(.LOCK_TO(LOCK_TO), .HOLD(HOLD), .RST_FREQ(RFREQ), .RST_VID(RVID)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .die_hot(die_hot), .lock_done(lock_done), .vid_out(vid_out), .pll_freq(pll_freq),
        .relock_req(relock_req), .core_unavail(core_unavail), .snoop_block(snoop_block),
        .thermal_irq(thermal_irq), .lock_err(lock_err)
    );

    always #2 clk = ~clk;   // 250 MHz

    int compared = 0, mismatched = 0;
    int dwell_exp = 2;
    int cycles = 0;
    bit resp_en = 1'b1;
    int resp_cnt = 0, resp_dly = 2;
    int irq_cnt = 0, busy_rises = 0;
    logic [PT_W-1:0] log_pt [64];
    int log_n = 0;

    function automatic logic [PT_W-1:0] mkpt(input int f, input int v);
        return {FREQ_W'(f), VID_W'(v)};
    endfunction

    function automatic logic [PT_W-1:0] now_pt();
        return {pll_freq, vid_out};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            finish_run();
        end
    end

    // Clock generator model: acknowledge after a delay unless disabled.
    always @(negedge clk) begin
        if (!relock_req || !resp_en || lock_done) begin
            lock_done <= 1'b0;
            resp_cnt  <= 0;
        end else if (resp_cnt >= resp_dly) begin
            lock_done <= 1'b1;
        end else begin
            resp_cnt <= resp_cnt + 1;
        end
    end

    // Port monitor: step size, dwell gaps, phase ordering, completion log.
    logic [VID_W-1:0]  p_vid;
    logic              p_busy = 1'b0, p_relock = 1'b0;
    logic [FREQ_W-1:0] start_freq;
    bit relock_seen, relock_ended, chg_after_start, chg_before_end, step_valid;
    int gap;
    always @(negedge clk) begin
        if (!rst) begin
            if (thermal_irq) irq_cnt++;
            if (core_unavail && !p_busy) begin
                busy_rises++;
                start_freq = pll_freq;
                relock_seen = 0; relock_ended = 0;
                chg_after_start = 0; chg_before_end = 0;
                step_valid = 0; gap = 0;
            end
            if (vid_out != p_vid) begin
                check("R2", "vid step size", (int'(vid_out) - int'(p_vid)) * (int'(vid_out) - int'(p_vid)), 1);
                check("R5", "busy during vid change", int'(core_unavail), 1);
                if (step_valid) check("R2", "dwell gap", gap, dwell_exp);
                step_valid = 1; gap = 0;
                if (relock_seen) chg_after_start = 1;
                if (!relock_ended) chg_before_end = 1;
            end else begin
                gap++;
            end
            if (relock_req && !p_relock) relock_seen = 1;
            if (!relock_req && p_relock) relock_ended = 1;
            if (relock_req && !core_unavail) check("R5", "relock outside move", 1, 0);
            if (snoop_block != core_unavail) check("R5", "snoop_block vs core_unavail", int'(snoop_block), int'(core_unavail));
            if (!core_unavail && p_busy) begin
                if (relock_seen && vid_out != p_vid_at_start) begin
                    if (pll_freq > start_freq) check("R3", "up: vid moved after relock", int'(chg_after_start), 0);
                    else check("R3", "down: vid moved before relock end", int'(chg_before_end), 0);
                end
                if (log_n < 64) log_pt[log_n] = now_pt();
                log_n++;
            end
        end
        p_vid = vid_out; p_busy = core_unavail; p_relock = relock_req;
    end

    logic [VID_W-1:0] p_vid_at_start;
    always @(negedge clk) if (core_unavail && !p_busy) p_vid_at_start <= p_vid;

    task automatic wr(input int addr, input logic [PT_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (3) @(negedge clk);
        while (quiet < 4) begin
            @(negedge clk);
            quiet = core_unavail ? 0 : quiet + 1;
        end
    endtask

    task automatic move_to(input logic [PT_W-1:0] pt, input string req);
        wr(0, pt);
        wait_idle();
        check(req, "final point", int'(now_pt()), int'(pt));
    endtask

    initial begin
        logic [PT_W-1:0] a, c, lowp, swp, keep;
        int br, ic, n0;
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "vid_out", int'(vid_out), RVID);
        check("R1", "pll_freq", int'(pll_freq), RFREQ);
        check("R1", "busy", int'(core_unavail | snoop_block | relock_req), 0);
        check("R1", "irq/err", int'(thermal_irq | lock_err), 0);

        // R4 request for the current point
        br = busy_rises;
        wr(0, mkpt(RFREQ, RVID));
        repeat (10) @(negedge clk);
        check("R4", "no move started", busy_rises, br);
        check("R4", "point unchanged", int'(now_pt()), int'(mkpt(RFREQ, RVID)));

        // Directed up (freq rise, voltage raise) and down moves
        move_to(mkpt(20, 22), "R3");
        move_to(mkpt(3, 40), "R3");
        move_to(mkpt(3, 36), "R2");       // voltage only
        move_to(mkpt(12, 36), "R3");      // frequency only

        // R2/R3 constrained random moves with random dwell
        for (int i = 0; i < 10; i++) begin
            dwell_exp = int'($urandom_range(0, 3));
            wr(2, PT_W'(dwell_exp));
            move_to(mkpt(int'($urandom_range(0, 31)), int'($urandom_range(0, 63))), "R3");
        end
        check("R10", "no error with prompt lock", int'(lock_err), 0);

        // R6 deferral: A runs, B is overridden by C, C runs after A
        dwell_exp = 3;
        wr(2, PT_W'(3));
        a = mkpt(int'(pll_freq) ^ 5'd1, (int'(vid_out) + 20) % 64);
        c = mkpt(int'(a[10:6]) ^ 5'd4, (int'(a[5:0]) + 7) % 64);
        n0 = log_n;
        wr(0, a);
        repeat (3) @(negedge clk);
        check("R6", "first move running", int'(core_unavail), 1);
        wr(0, mkpt(1, 1));
        wr(0, c);
        wait_idle();
        check("R6", "completions", log_n - n0, 2);
        check("R6", "first completion", int'(log_pt[n0 % 64]), int'(a));
        check("R6", "second completion", int'(log_pt[(n0 + 1) % 64]), int'(c));

        // R7 thermal down-move
        keep = now_pt();
        lowp = mkpt(2, 50);
        wr(1, lowp);
        ic = irq_cnt;
        die_hot = 1'b1;
        wait_idle();
        check("R7", "low point reached", int'(now_pt()), int'(lowp));
        check("R7", "irq on down-move", irq_cnt - ic, 1);

        // R8 still hot after several holds: stay low, no irq
        repeat (HOLD * 3) @(negedge clk);
        check("R8", "stays low while hot", int'(now_pt()), int'(lowp));
        check("R8", "no irq while hot", irq_cnt - ic, 1);

        // R9 request during throttle is recorded only
        br = busy_rises;
        swp = mkpt(25, 15);
        wr(0, swp);
        repeat (20) @(negedge clk);
        check("R9", "no move during throttle", busy_rises, br);
        check("R9", "point held", int'(now_pt()), int'(lowp));
        die_hot = 1'b0;
        repeat (HOLD + 10) @(negedge clk);
        wait_idle();
        check("R9", "released to recorded request", int'(now_pt()), int'(swp));
        check("R8", "irq on up-move", irq_cnt - ic, 2);

        // R8 release without request returns to the saved point
        ic = irq_cnt;
        die_hot = 1'b1;
        repeat (5) @(negedge clk);
        die_hot = 1'b0;
        wait_idle();
        repeat (HOLD + 10) @(negedge clk);
        wait_idle();
        check("R8", "restored saved point", int'(now_pt()), int'(swp));
        check("R8", "two thermal irqs", irq_cnt - ic, 2);
        if (keep == 0) check("R8", "unused", 0, 0);

        // R10 lock timeout
        resp_en = 1'b0;
        check("R10", "error clear before timeout", int'(lock_err), 0);
        wr(0, mkpt(int'(pll_freq) ^ 5'd8, int'(vid_out)));
        wait_idle();
        check("R10", "error set", int'(lock_err), 1);
        check("R10", "move completed", int'(pll_freq), int'(swp[10:6]) ^ 8);
        resp_en = 1'b1;
        move_to(mkpt(9, 9), "R10");
        check("R10", "error sticky", int'(lock_err), 1);

        finish_run();
    end

endmodule